// File: doc/BRIEF.md
# Watchdog Countdown Timer with Tick Prescaler

This block is a register-mapped watchdog. A prescaler divides the reference clock by a programmable count and emits one tick per period. A 24-bit countdown loses two on every tick. When the countdown runs out, the block raises a one-cycle reset request. Software can also raise that request at once by writing a trigger bit. Three halt inputs can freeze the countdown: one for each processor's debug state and one for external debug bus activity. Each input has its own pause enable bit. A reason register records whether the last request came from expiry or from the trigger.

Software reaches the block through a simple single-cycle bus with request, write enable, byte address and write data. Read data comes back on the next cycle. The word index is address bits [5:2]: 0 control, 1 load, 2 reason, 3 to 10 scratch words 0 to 7, 11 tick control. Eight scratch words are free for software. The block's own request clears nothing, so they keep their contents across it. The reset fabric that acts on the request lies outside the block.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0x0700_0000 (enable 0, all three pause enables 1, countdown 0), tick control reads 0x0000_0200 (prescaler enabled, period 0), and reason, load and scratch words read 0.
- R2: Each scratch word (index 3 to 10) returns the last 32-bit value written to it, and keeps it through a watchdog request.
- R3: A write to load (index 1) sets the countdown to wdata[23:0], which control bits [23:0] then read back. Load always reads 0.
- R4: Tick control is laid out as period [8:0], prescaler enable [9], read-only running [10] and read-only remaining count [19:11]. With a nonzero period P and the enable set, a tick falls every P cycles, and the first tick lands P cycles after the write. A period of 0 gives no ticks, and running reads 0.
- R5: With control enable (bit 30) set, each tick lowers the countdown by 2. With enable clear, the countdown holds.
- R6: Pause enables at control bits 26, 25 and 24 freeze the countdown while cpu1_halt_i, cpu0_halt_i or jtag_busy_i respectively is high. A halt input whose own pause bit is clear has no effect.
- R7: A tick that finds the countdown below 2 while it is enabled and unpaused sets the countdown to 0, pulses wdog_req_o for one cycle on the next cycle, and sets reason to 0b01 (timer bit 0 set, force bit 1 clear). From load L and period P, the request rises (L/2+1)*P cycles after the prescaler is started.
- R8: Writing control with bit 31 set pulses wdog_req_o for one cycle on the next cycle and sets reason to 0b10. Bit 31 always reads 0.
- R9: When a trigger write and an expiry fall in the same cycle, a single request pulse results and reason reads 0b10.
- R10: Read data appears the cycle after a read request and holds until the next read. Word indices 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address; bits [5:2] select the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| cpu1_halt_i | input | 1 | Processor 1 is halted in debug |
| cpu0_halt_i | input | 1 | Processor 0 is halted in debug |
| jtag_busy_i | input | 1 | External debugger is using the bus |
| wdog_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
Software's trigger write and the countdown's expiry can land on the same clock edge. Both drive the one request flop and both write the reason register. The bench provokes this by starting the prescaler from a known phase with a small load. It then places the trigger write's edge exactly (L/2+1)*P cycles later. The result must be a single request pulse and a reason of force-only, with the timer flag left clear.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned ADDR_W      = 6;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned CNT_W       = 24;
  localparam int unsigned CYC_W       = 9;
  localparam int unsigned NUM_SCRATCH = 8;
  localparam int unsigned IDX_W       = ADDR_W - 2;

  // word indices
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_LOAD   = 1;
  localparam int unsigned IDX_REASON = 2;
  localparam int unsigned IDX_SCR0   = 3;
  localparam int unsigned IDX_TICK   = IDX_SCR0 + NUM_SCRATCH;

  // control bit positions
  localparam int unsigned CTRL_TRIG_B  = 31;
  localparam int unsigned CTRL_EN_B    = 30;
  localparam int unsigned CTRL_PAUSE_L = 24;
  localparam int unsigned NUM_HALT     = 3;

  // tick bit positions
  localparam int unsigned TICK_EN_B  = CYC_W;
  localparam int unsigned TICK_RUN_B = CYC_W + 1;
  localparam int unsigned TICK_REM_L = CYC_W + 2;

  typedef struct packed {
    logic                enable;
    logic [NUM_HALT-1:0] pause_en; // [2] cpu1, [1] cpu0, [0] jtag
  } ctrl_t;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_TIMER = 2'b01,
    RSN_FORCE = 2'b10
  } reason_e;
endpackage

// File: rtl/wdog_tick_gen.sv
`timescale 1ns/1ps
module wdog_tick_gen #(
  parameter int unsigned CYC_W = wdog_pkg::CYC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CYC_W-1:0] cfg_cycles_i,
  input  logic             cfg_en_i,
  output logic [CYC_W-1:0] cycles_o,
  output logic             en_o,
  output logic             running_o,
  output logic [CYC_W-1:0] remain_o,
  output logic             tick_o
);
  logic [CYC_W-1:0] cycles_q, remain_q;
  logic             en_q;

  assign running_o = en_q && (cycles_q != '0);
  assign tick_o    = running_o && (remain_q <= CYC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycles_q <= '0;
      en_q     <= 1'b1;
      remain_q <= '0;
    end else if (cfg_we_i) begin
      cycles_q <= cfg_cycles_i;
      en_q     <= cfg_en_i;
      remain_q <= cfg_cycles_i;
    end else if (running_o) begin
      remain_q <= tick_o ? cycles_q : remain_q - CYC_W'(1);
    end else begin
      remain_q <= cycles_q;
    end
  end

  assign cycles_o = cycles_q;
  assign en_o     = en_q;
  assign remain_o = remain_q;

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && !cfg_we_i && !tick_o |=> remain_q == $past(remain_q) - CYC_W'(1));
  // R4
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !cfg_we_i && cycles_q > CYC_W'(1) |=> !tick_o);
  // R4
  idle_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !cfg_we_i |=> remain_q == $past(cycles_q));
endmodule

// File: rtl/wdog_countdown.sv
`timescale 1ns/1ps
module wdog_countdown #(
  parameter int unsigned CNT_W    = wdog_pkg::CNT_W,
  parameter int unsigned NUM_HALT = wdog_pkg::NUM_HALT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                enable_i,
  input  logic [NUM_HALT-1:0] pause_en_i,
  input  logic [NUM_HALT-1:0] halt_i,
  input  logic                load_we_i,
  input  logic [CNT_W-1:0]    load_val_i,
  input  logic                trig_i,
  output logic [CNT_W-1:0]    count_o,
  output logic                fire_o,
  output logic [1:0]          reason_o
);
  import wdog_pkg::*;

  localparam logic [CNT_W-1:0] STEP = CNT_W'(2);

  logic [CNT_W-1:0] count_q;
  logic             fire_q;
  reason_e          reason_q;
  logic             hold, active, expire;

  assign hold   = |(pause_en_i & halt_i);
  assign active = tick_i && enable_i && !hold;
  assign expire = active && !load_we_i && (count_q < STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (load_we_i) begin
      count_q <= load_val_i;
    end else if (active) begin
      count_q <= (count_q < STEP) ? '0 : count_q - STEP;
    end
  end

  // trigger outranks expiry in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else begin
      fire_q <= trig_i || expire;
      if (trig_i)      reason_q <= RSN_FORCE;
      else if (expire) reason_q <= RSN_TIMER;
    end
  end

  assign count_o  = count_q;
  assign fire_o   = fire_q;
  assign reason_o = reason_q;

  // R8
  trig_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> fire_o && reason_o == 2'b10);
  // R7
  fire_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $countones(reason_o) == 1);
  // R5
  no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_we_i |=> count_o <= $past(count_o));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_we_i && (hold || !enable_i || !tick_i) |=> $stable(count_o));
  // R7
  expire_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !trig_i && !load_we_i |-> reason_o != 2'b01 || count_o == '0);
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs #(
  parameter int unsigned ADDR_W      = wdog_pkg::ADDR_W,
  parameter int unsigned DATA_W      = wdog_pkg::DATA_W,
  parameter int unsigned CNT_W       = wdog_pkg::CNT_W,
  parameter int unsigned CYC_W       = wdog_pkg::CYC_W,
  parameter int unsigned NUM_SCRATCH = wdog_pkg::NUM_SCRATCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output wdog_pkg::ctrl_t   ctrl_o,
  output logic              trig_o,
  output logic              load_we_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              tick_we_o,
  output logic [CYC_W-1:0]  tick_cycles_o,
  output logic              tick_en_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        reason_i,
  input  logic [CYC_W-1:0]  tick_cycles_i,
  input  logic              tick_en_i,
  input  logic              tick_running_i,
  input  logic [CYC_W-1:0]  tick_remain_i
);
  import wdog_pkg::*;

  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  logic              wr, rd;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] scr_q [NUM_SCRATCH];
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign idx = addr_i[ADDR_W-1:2];
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.enable   <= 1'b0;
      ctrl_q.pause_en <= '1;
    end else if (wr && idx == IW'(IDX_CTRL)) begin
      ctrl_q.enable   <= wdata_i[CTRL_EN_B];
      ctrl_q.pause_en <= wdata_i[CTRL_PAUSE_L +: NUM_HALT];
    end
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              scr_q[g] <= '0;
      else if (wr && idx == IW'(IDX_SCR0 + g))  scr_q[g] <= wdata_i;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign trig_o        = wr && idx == IW'(IDX_CTRL) && wdata_i[CTRL_TRIG_B];
  assign load_we_o     = wr && idx == IW'(IDX_LOAD);
  assign load_val_o    = wdata_i[CNT_W-1:0];
  assign tick_we_o     = wr && idx == IW'(IDX_TICK);
  assign tick_cycles_o = wdata_i[CYC_W-1:0];
  assign tick_en_o     = wdata_i[TICK_EN_B];

  always_comb begin
    rd_mux = '0;
    if (idx == IW'(IDX_CTRL)) begin
      rd_mux[CTRL_EN_B]                  = ctrl_q.enable;
      rd_mux[CTRL_PAUSE_L +: NUM_HALT]   = ctrl_q.pause_en;
      rd_mux[CNT_W-1:0]                  = count_i;
    end else if (idx == IW'(IDX_REASON)) begin
      rd_mux[1:0] = reason_i;
    end else if (idx == IW'(IDX_TICK)) begin
      rd_mux[CYC_W-1:0]              = tick_cycles_i;
      rd_mux[TICK_EN_B]              = tick_en_i;
      rd_mux[TICK_RUN_B]             = tick_running_i;
      rd_mux[TICK_REM_L +: CYC_W]    = tick_remain_i;
    end
    for (int i = 0; i < NUM_SCRATCH; i++) begin
      if (idx == IW'(IDX_SCR0 + i)) rd_mux = scr_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  // R8
  trig_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && idx == IW'(IDX_CTRL) |=> !rdata_o[CTRL_TRIG_B]);
  // R3
  load_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && idx == IW'(IDX_LOAD) |=> rdata_o == '0);
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int unsigned ADDR_W = wdog_pkg::ADDR_W,
  parameter int unsigned DATA_W = wdog_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              cpu1_halt_i,
  input  logic              cpu0_halt_i,
  input  logic              jtag_busy_i,
  output logic              wdog_req_o
);
  import wdog_pkg::*;

  ctrl_t            ctrl;
  logic             trig, load_we, tick_we, tick_en_w, tick;
  logic [CNT_W-1:0] load_val, count;
  logic [CYC_W-1:0] tick_cyc_w, tick_cyc, tick_rem;
  logic             tick_en, tick_run;
  logic [1:0]       reason;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .ctrl_o(ctrl), .trig_o(trig),
    .load_we_o(load_we), .load_val_o(load_val),
    .tick_we_o(tick_we), .tick_cycles_o(tick_cyc_w), .tick_en_o(tick_en_w),
    .count_i(count), .reason_i(reason),
    .tick_cycles_i(tick_cyc), .tick_en_i(tick_en),
    .tick_running_i(tick_run), .tick_remain_i(tick_rem)
  );

  wdog_tick_gen u_tick (
    .clk_i, .rst_ni,
    .cfg_we_i(tick_we), .cfg_cycles_i(tick_cyc_w), .cfg_en_i(tick_en_w),
    .cycles_o(tick_cyc), .en_o(tick_en), .running_o(tick_run),
    .remain_o(tick_rem), .tick_o(tick)
  );

  wdog_countdown u_cnt (
    .clk_i, .rst_ni,
    .tick_i(tick), .enable_i(ctrl.enable), .pause_en_i(ctrl.pause_en),
    .halt_i({cpu1_halt_i, cpu0_halt_i, jtag_busy_i}),
    .load_we_i(load_we), .load_val_i(load_val), .trig_i(trig),
    .count_o(count), .fire_o(wdog_req_o), .reason_o(reason)
  );

  // R9
  single_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig && tick |=> wdog_req_o && reason == 2'b10);
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        h1 = 1'b0, h0 = 1'b0, hj = 1'b0, wreq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  localparam logic [5:0] A_CTRL = 6'h00, A_LOAD = 6'h04, A_RSN = 6'h08,
                         A_SCR0 = 6'h0C, A_TICK = 6'h2C;
  localparam logic [31:0] EN = 32'h4000_0000, TRIG = 32'h8000_0000;

  always #10 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cpu1_halt_i(h1), .cpu0_halt_i(h0), .jtag_busy_i(hj), .wdog_req_o(wreq)
  );

  function automatic int exp_expiry(int l, int c);
    return (l / 2 + 1) * c;
  endfunction

  function automatic logic [31:0] exp_tick(int c, bit en, bit run, int rem);
    return (32'(rem) << 11) | (32'(run) << 10) | (32'(en) << 9) | 32'(c);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1; req = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  // stop prescaler, load, enable, start prescaler; return cycles to request
  task automatic measure(int l, int c, output int n);
    wr(A_TICK, 32'h0);
    wr(A_LOAD, 32'(l));
    wr(A_CTRL, EN);
    wr(A_TICK, 32'h200 | 32'(c));
    n = 0;
    while (n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (wreq) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] scr [8];
    int n, l, c;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0700_0000);
    rd(A_TICK, d); chk("R1 tick", d, 32'h0000_0200);
    rd(A_RSN, d);  chk("R1 reason", d, 0);
    rd(A_SCR0, d); chk("R1 scratch0", d, 0);
    rd(A_LOAD, d); chk("R3 load reads 0", d, 0);
    rd(6'h30, d);  chk("R10 unmapped", d, 0);

    // R3 load readback
    wr(A_LOAD, 32'hFFAB_CDEF);
    rd(A_CTRL, d); chk("R3 load value", d & 32'hFF_FFFF, 32'hAB_CDEF);

    // R4 tick layout and zero period
    wr(A_TICK, 32'h200 | 5);
    rd(A_TICK, d); chk("R4 tick running", d, exp_tick(5, 1, 1, 5));
    wr(A_TICK, 32'h200);
    rd(A_TICK, d); chk("R4 period zero", d, exp_tick(0, 1, 0, 0));
    wr(A_CTRL, EN);
    wr(A_LOAD, 40);
    repeat (30) @(posedge clk);
    rd(A_CTRL, d); chk("R4 no ticks", d & 32'hFF_FFFF, 40);

    // R5 exact decrement by 2 per tick
    wr(A_TICK, 0); wr(A_LOAD, 100); wr(A_CTRL, EN);
    wr(A_TICK, 32'h200 | 3);
    repeat (15) @(posedge clk);
    rd(A_CTRL, d); chk("R5 decrement", d & 32'hFF_FFFF, 90);
    // R5 disabled holds
    wr(A_CTRL, 0); wr(A_TICK, 32'h200 | 1); wr(A_LOAD, 50);
    repeat (10) @(posedge clk);
    rd(A_CTRL, d); chk("R5 disabled hold", d & 32'hFF_FFFF, 50);

    // R6 each pause source
    wr(A_TICK, 32'h200 | 2);
    for (int s = 0; s < 3; s++) begin
      h1 = (s == 2); h0 = (s == 1); hj = (s == 0);
      wr(A_CTRL, EN | (32'h0100_0000 << s));
      wr(A_LOAD, 200);
      repeat (20) @(posedge clk);
      rd(A_CTRL, d); chk($sformatf("R6 paused src%0d", s), d & 32'hFF_FFFF, 200);
      wr(A_CTRL, EN | (32'h0700_0000 & ~(32'h0100_0000 << s)));
      repeat (20) @(posedge clk);
      rd(A_CTRL, d); chk($sformatf("R6 other bits src%0d", s), 32'((d & 32'hFF_FFFF) < 200), 1);
      h1 = 0; h0 = 0; hj = 0;
    end

    // R7 directed expiry corners
    measure(0, 1, n); chk("R7 L0 P1", n, exp_expiry(0, 1));
    measure(1, 3, n); chk("R7 L1 P3", n, exp_expiry(1, 3));
    measure(2, 4, n); chk("R7 L2 P4", n, exp_expiry(2, 4));
    @(posedge clk); #1; chk("R7 one cycle", wreq, 0);
    rd(A_RSN, d); chk("R7 reason timer", d, 1);
    rd(A_CTRL, d); chk("R7 saturate 0", d & 32'hFF_FFFF, 0);
    // R7 random
    for (int k = 0; k < 6; k++) begin
      l = $urandom_range(0, 60); c = $urandom_range(1, 12);
      measure(l, c, n);
      chk($sformatf("R7 rand L%0d P%0d", l, c), n, exp_expiry(l, c));
    end

    // R8 trigger
    wr(A_TICK, 0);
    wr(A_CTRL, TRIG);
    chk("R8 pulse", wreq, 1);
    @(posedge clk); #1; chk("R8 one cycle", wreq, 0);
    rd(A_RSN, d); chk("R8 reason force", d, 2);
    rd(A_CTRL, d); chk("R8 trig reads 0", d >> 31, 0);

    // R9 trigger on expiry edge (L=4,P=3 -> 9 cycles)
    measure(0, 1, n);
    wr(A_TICK, 0); wr(A_LOAD, 4); wr(A_CTRL, EN);
    wr(A_TICK, 32'h200 | 3);
    repeat (8) @(posedge clk);
    wr(A_CTRL, TRIG | EN);
    chk("R9 pulse", wreq, 1);
    @(posedge clk); #1; chk("R9 single", wreq, 0);
    rd(A_RSN, d); chk("R9 reason force", d, 2);

    // R2 scratch, random data, retained over request
    for (int i = 0; i < 8; i++) begin
      scr[i] = $urandom();
      wr(A_SCR0 + 6'(4 * i), scr[i]);
    end
    wr(A_CTRL, TRIG);
    for (int i = 0; i < 8; i++) begin
      rd(A_SCR0 + 6'(4 * i), d);
      chk($sformatf("R2 scratch%0d", i), d, scr[i]);
    end

    // R10 read data holds across writes
    rd(A_SCR0, d);
    wr(A_SCR0, ~scr[0]);
    @(negedge clk); chk("R10 hold", rdata, scr[0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule